// File: doc/BRIEF.md
# Double-Buffered Gamma Lookup Controller

This block holds a per-channel gamma correction table in two banks of storage, A and B, and lets a host load one bank while the pixel path reads the other. The host reaches it through a small register interface with four registers: a control register, a write pointer, a data port and a power register. Each data write stores one entry into the bank the host has chosen, in every colour channel enabled by a three-bit colour mask. The pointer then advances by one, so a run of data writes fills consecutive entries.

The host names the table mode (bypass or table lookup) and the bank the pixel path should read. Both choices are held as pending values and copied into the active configuration only on a frame-start pulse, so a frame never sees a bank switch part-way through. A read-only view of the active mode and bank lets software pick the idle bank for its next load.

The table storage has a power control. A power state machine has three states: PWR_AWAKE (storage usable), PWR_ASLEEP (storage gated) and PWR_WAKING (a fixed wake-up delay). PWR_AWAKE goes to PWR_ASLEEP when the force field reads 3. PWR_ASLEEP goes to PWR_WAKING when the force field reads 0. PWR_WAKING counts down and then enters PWR_AWAKE, or drops back to PWR_ASLEEP if the force field returns to 3. While the storage is not awake, or the active mode is not the table mode, pixels pass through unchanged with the same one-cycle latency as a lookup.

Top module: `gamma_dbuf_lut`

## Requirements
- R1: After reset the active mode is bypass (0) and the active bank is 0. The write pointer reads 0, the power status reads 0 (powered), the force field reads 0 and pix_out_valid is 0.
- R2: Register map, with address in reg_addr: 0 is control, 1 is pointer, 2 is data, 3 is power. A control write sets pending mode [1:0], pending read bank [4], host bank [8] and colour mask [14:12]. Control readback also shows active mode at [17:16] and active bank at [20]. The active fields change only in the cycle after a frame_start pulse, and then they take the pending values.
- R3: A data write stores reg_wdata[11:0] at the pointer in the host bank (0 = A, 1 = B) for each channel whose mask bit is set: bit 2 red, bit 1 green, bit 0 blue. The pointer then increments by one. Mask 7 writes all three channels.
- R4: A pointer write sets the pointer to min(value, 34), read back at [5:0]. When the pointer is 34, a data write stores nothing and the pointer stays at 34.
- R5: With active mode 2 and storage awake, a valid pixel returns, one cycle later, the entry at index min(v>>6, 33) of the active bank for each channel. Channel v is its 12-bit field of pix_in, red at [35:24], green at [23:12], blue at [11:0]. pix_out_valid follows pix_valid with one cycle of delay.
- R6: With any active mode other than 2, pix_out equals pix_in one cycle after a valid pixel.
- R7: Power register: force at [1:0], status at [8]. Writing force 3 sets the status to 1 after the next cycle, and pixels then bypass. Writing force 0 from the gated state keeps the status at 1 until exactly 4 cycles after the write edge, when it reads 0.
- R8: Writes to the bank that is not active do not change the pixel output read from the active bank.
- R9: Force values 1 and 2 leave a settled power state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| frame_start | input | 1 | Frame boundary pulse that applies the pending mode and bank |
| pix_valid | input | 1 | Input pixel valid |
| pix_in | input | 36 | Input pixel, red/green/blue 12 bits each |
| pix_out_valid | output | 1 | Output pixel valid, one cycle after pix_valid |
| pix_out | output | 36 | Corrected (or bypassed) pixel |

## Verification
The hardest case to reach from the ports is a host load into one bank while the other bank drives the pixel path, with a pending bank change that has not yet been applied. The stimulus fully loads bank A and activates it. It then loads bank B with different values through several masks and sets B as the pending bank. Before the frame-start pulse it sweeps every lookup index and expects only bank A contents; after the pulse it sweeps again and expects bank B. The power wake-up delay is reached by gating the storage, holding it with the neutral force values, and then sampling the status on each cycle after the wake request.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
    localparam int NUM_CH    = 3;
    localparam int NUM_BANKS = 2;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_INDEX = 2'd1;
    localparam logic [1:0] ADDR_DATA  = 2'd2;
    localparam logic [1:0] ADDR_POWER = 2'd3;

    localparam logic [1:0] MODE_BYPASS = 2'd0;
    localparam logic [1:0] MODE_TABLE  = 2'd2;

    localparam logic [1:0] FORCE_ON  = 2'd0;
    localparam logic [1:0] FORCE_OFF = 2'd3;

    typedef enum logic [1:0] {
        PWR_AWAKE  = 2'd0,
        PWR_ASLEEP = 2'd1,
        PWR_WAKING = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/gamma_pwr_fsm.sv
module gamma_pwr_fsm
    import gamma_lut_pkg::*;
#(
    parameter int WAKE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] force_req,
    output logic       pwr_on,
    output logic       pwr_down
);
    localparam int CW = (WAKE_CYCLES > 2) ? $clog2(WAKE_CYCLES) : 1;
    localparam logic [CW-1:0] WAKE_LOAD = CW'(WAKE_CYCLES - 2);

    pwr_state_e state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PWR_AWAKE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            PWR_AWAKE: begin
                if (force_req == FORCE_OFF) state_nxt = PWR_ASLEEP;
            end
            PWR_ASLEEP: begin
                if (force_req == FORCE_ON) begin
                    state_nxt = PWR_WAKING;
                    cnt_nxt   = WAKE_LOAD;
                end
            end
            PWR_WAKING: begin
                if (force_req == FORCE_OFF) begin
                    state_nxt = PWR_ASLEEP;
                end else if (cnt == '0) begin
                    state_nxt = PWR_AWAKE;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            default: state_nxt = PWR_ASLEEP;
        endcase
    end

    always_comb begin
        pwr_on   = (state == PWR_AWAKE);
        pwr_down = (state != PWR_AWAKE);
    end

    // R7: a force-off request while awake gates the storage next cycle
    p_sleep_on_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PWR_AWAKE && force_req == FORCE_OFF) |=> pwr_down);

    // R7: a wake request from the gated state cannot power up in one cycle
    p_no_instant_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PWR_ASLEEP) |=> !pwr_on);

    // R9: neutral force values keep a settled state
    p_neutral_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((force_req == 2'd1 || force_req == 2'd2) && state != PWR_WAKING)
        |=> $stable(state));
endmodule

// File: rtl/gamma_reg_file.sv
module gamma_reg_file
    import gamma_lut_pkg::*;
#(
    parameter int DW    = 12,
    parameter int DEPTH = 34,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              frame_start,
    input  logic              pwr_down,
    output logic [1:0]        mode_cur,
    output logic              sel_cur,
    output logic              host_bank,
    output logic [NUM_CH-1:0] wr_en,
    output logic [AW-1:0]     wr_idx,
    output logic [DW-1:0]     wr_data,
    output logic [1:0]        force_req
);
    logic [1:0]        mode_nxt;
    logic              sel_nxt;
    logic [NUM_CH-1:0] color_mask;
    logic [PW-1:0]     wptr;
    logic              data_wr;
    logic              room;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign data_wr = reg_wr && (reg_addr == ADDR_DATA);
    assign room    = (wptr < PW'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_nxt   <= MODE_BYPASS;
            sel_nxt    <= 1'b0;
            host_bank  <= 1'b0;
            color_mask <= '1;
            mode_cur   <= MODE_BYPASS;
            sel_cur    <= 1'b0;
            wptr       <= '0;
            force_req  <= FORCE_ON;
        end else begin
            if (reg_wr && reg_addr == ADDR_CTRL) begin
                mode_nxt   <= reg_wdata[1:0];
                sel_nxt    <= reg_wdata[4];
                host_bank  <= reg_wdata[8];
                color_mask <= reg_wdata[14:12];
            end
            if (reg_wr && reg_addr == ADDR_POWER) begin
                force_req <= reg_wdata[1:0];
            end
            if (reg_wr && reg_addr == ADDR_INDEX) begin
                if (reg_wdata > 32'(DEPTH)) wptr <= PW'(DEPTH);
                else                        wptr <= reg_wdata[PW-1:0];
            end else if (data_wr && room) begin
                wptr <= wptr + 1'b1;
            end
            if (frame_start) begin
                mode_cur <= mode_nxt;
                sel_cur  <= sel_nxt;
            end
        end
    end

    always_comb begin
        wr_en   = (data_wr && room) ? color_mask : '0;
        wr_idx  = AW'(wptr);
        wr_data = reg_wdata[DW-1:0];
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[1:0]   = mode_nxt;
                reg_rdata[4]     = sel_nxt;
                reg_rdata[8]     = host_bank;
                reg_rdata[14:12] = color_mask;
                reg_rdata[17:16] = mode_cur;
                reg_rdata[20]    = sel_cur;
            end
            ADDR_INDEX: reg_rdata[PW-1:0] = wptr;
            ADDR_DATA:  reg_rdata = '0;
            ADDR_POWER: begin
                reg_rdata[1:0] = force_req;
                reg_rdata[8]   = pwr_down;
            end
            default: reg_rdata = '0;
        endcase
    end

    // R4: pointer never passes the table depth
    p_ptr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wptr <= PW'(DEPTH));

    // R4: a data write at a full pointer leaves it full
    p_full_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !room) |=> (wptr == PW'(DEPTH)));

    // R2: active fields move only on a frame boundary
    p_cur_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(mode_cur) && $stable(sel_cur)));

    // R2: on a frame boundary the pending values become active
    p_cur_apply_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (mode_cur == $past(mode_nxt) && sel_cur == $past(sel_nxt)));
endmodule

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank
    import gamma_lut_pkg::*;
#(
    parameter int DW    = 12,
    parameter int DEPTH = 34,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic [NUM_CH-1:0]    wr_en,
    input  logic [AW-1:0]        wr_idx,
    input  logic [DW-1:0]        wr_data,
    input  logic [NUM_CH*AW-1:0] rd_idx,
    output logic [NUM_CH*DW-1:0] rd_data
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [DW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en[c]) mem[wr_idx] <= wr_data;
        end

        assign rd_data[c*DW +: DW] = mem[rd_idx[c*AW +: AW]];
    end
endmodule

// File: rtl/gamma_pix_path.sv
module gamma_pix_path
    import gamma_lut_pkg::*;
#(
    parameter int DW    = 12,
    parameter int DEPTH = 34,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  pix_valid,
    input  logic [NUM_CH*DW-1:0]                  pix_in,
    input  logic [1:0]                            mode_cur,
    input  logic                                  sel_cur,
    input  logic                                  pwr_on,
    input  logic [NUM_BANKS-1:0][NUM_CH*DW-1:0]   bank_rd,
    output logic [NUM_CH*AW-1:0]                  rd_idx,
    output logic                                  pix_out_valid,
    output logic [NUM_CH*DW-1:0]                  pix_out
);
    localparam int SHIFT = DW - AW;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic                 use_table;
    logic [NUM_CH*DW-1:0] looked_up;

    assign use_table = (mode_cur == MODE_TABLE) && pwr_on;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_idx
        logic [AW-1:0] raw;
        assign raw = pix_in[c*DW + SHIFT +: AW];
        assign rd_idx[c*AW +: AW] = (raw > LAST) ? LAST : raw;
    end

    assign looked_up = bank_rd[sel_cur];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out_valid <= 1'b0;
            pix_out       <= '0;
        end else begin
            pix_out_valid <= pix_valid;
            if (pix_valid) pix_out <= use_table ? looked_up : pix_in;
        end
    end

    // R5: output valid trails input valid by one cycle
    p_valid_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> pix_out_valid);
    p_valid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !pix_out_valid);

    // R6: bypass returns the input pixel
    p_bypass_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && mode_cur != MODE_TABLE) |=> (pix_out == $past(pix_in)));

    // R7: gated storage also forces pass-through
    p_gated_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pwr_on) |=> (pix_out == $past(pix_in)));
endmodule

// File: rtl/gamma_dbuf_lut.sv
module gamma_dbuf_lut
    import gamma_lut_pkg::*;
#(
    parameter int DW          = 12,
    parameter int DEPTH       = 34,
    parameter int WAKE_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 frame_start,
    input  logic                 pix_valid,
    input  logic [NUM_CH*DW-1:0] pix_in,
    output logic                 pix_out_valid,
    output logic [NUM_CH*DW-1:0] pix_out
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(DEPTH + 1);

    logic [1:0]                          mode_cur;
    logic                                sel_cur;
    logic                                host_bank;
    logic [NUM_CH-1:0]                   wr_en;
    logic [AW-1:0]                       wr_idx;
    logic [DW-1:0]                       wr_data;
    logic [1:0]                          force_req;
    logic                                pwr_on;
    logic                                pwr_down;
    logic [NUM_CH*AW-1:0]                rd_idx;
    logic [NUM_BANKS-1:0][NUM_CH*DW-1:0] bank_rd;

    gamma_reg_file #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .frame_start(frame_start), .pwr_down(pwr_down),
        .mode_cur(mode_cur), .sel_cur(sel_cur), .host_bank(host_bank),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .force_req(force_req)
    );

    gamma_pwr_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_pwr (
        .clk(clk), .rst_n(rst_n), .force_req(force_req),
        .pwr_on(pwr_on), .pwr_down(pwr_down)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [NUM_CH-1:0] bank_we;
        assign bank_we = (host_bank == 1'(b)) ? wr_en : '0;

        gamma_lut_bank #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_bank (
            .clk(clk), .wr_en(bank_we), .wr_idx(wr_idx), .wr_data(wr_data),
            .rd_idx(rd_idx), .rd_data(bank_rd[b])
        );
    end

    gamma_pix_path #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_pix (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_in(pix_in),
        .mode_cur(mode_cur), .sel_cur(sel_cur), .pwr_on(pwr_on),
        .bank_rd(bank_rd), .rd_idx(rd_idx),
        .pix_out_valid(pix_out_valid), .pix_out(pix_out)
    );

    // R3: the storage is written only through a single enabled pointer slot
    p_write_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_en) |-> (wr_idx < AW'(DEPTH)));
endmodule

// File: tb/gamma_dbuf_lut_test.sv
`timescale 1ns/1ps
module gamma_dbuf_lut_test;
    localparam int DW = 12;
    localparam int DEPTH = 34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frame_start = 1'b0;
    logic        pix_valid = 1'b0;
    logic [35:0] pix_in = '0;
    logic        pix_out_valid;
    logic [35:0] pix_out;

    int n_chk = 0;
    int n_bad = 0;
    int model [2][3][DEPTH];
    int mptr = 0;
    int mbank = 0;
    int mmask = 7;

    always #4 clk = ~clk;

    gamma_dbuf_lut uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
        .pix_valid(pix_valid), .pix_in(pix_in),
        .pix_out_valid(pix_out_valid), .pix_out(pix_out)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // control write, keeping the bench's view of host bank and mask
    task automatic wctrl(input int mode, input int sel, input int hb, input int mask);
        wreg(2'd0, 32'(mode) | (32'(sel) << 4) | (32'(hb) << 8) | (32'(mask) << 12));
        mbank = hb; mmask = mask;
    endtask

    task automatic wptr(input int v);
        wreg(2'd1, 32'(v));
        mptr = (v > DEPTH) ? DEPTH : v;
    endtask

    task automatic wdata(input int v);
        wreg(2'd2, 32'(v));
        if (mptr < DEPTH) begin
            for (int c = 0; c < 3; c++)
                if (mmask[2-c]) model[mbank][c][mptr] = v & 12'hFFF;
            mptr++;
        end
    endtask

    task automatic fstart();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    // drive one pixel, return the output one cycle later
    task automatic pix(input int r, input int g, input int b, output logic [35:0] o);
        @(negedge clk);
        pix_valid = 1'b1;
        pix_in = {12'(r), 12'(g), 12'(b)};
        @(negedge clk);
        pix_valid = 1'b0;
        o = pix_out;
        check("R5 out_valid", longint'(pix_out_valid), 1);
    endtask

    function automatic int tidx(input int v);
        int k = v >> 6;
        return (k > DEPTH - 1) ? DEPTH - 1 : k;
    endfunction

    task automatic sweep(input string req, input int bank);
        logic [35:0] o;
        for (int k = 0; k < 64; k++) begin
            int r = (k << 6) | (k & 7);
            int g = ((63 - k) << 6) | 5;
            int b = (((k * 5) % 64) << 6) | 63;
            longint e;
            pix(r, g, b, o);
            e = (longint'(model[bank][0][tidx(r)]) << 24) |
                (longint'(model[bank][1][tidx(g)]) << 12) |
                 longint'(model[bank][2][tidx(b)]);
            check(req, longint'(o), e);
        end
    endtask

    task automatic bypass_chk(input string req, input int r, input int g, input int b);
        logic [35:0] o;
        pix(r, g, b, o);
        check(req, longint'(o), longint'({12'(r), 12'(g), 12'(b)}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [35:0] o;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rreg(2'd0, d); check("R1 active mode", longint'(d[17:16]), 0);
        check("R1 active bank", longint'(d[20]), 0);
        rreg(2'd1, d); check("R1 pointer", longint'(d[5:0]), 0);
        rreg(2'd3, d); check("R1 power status", longint'(d[8]), 0);
        check("R1 force", longint'(d[1:0]), 0);
        check("R1 out_valid", longint'(pix_out_valid), 0);

        // R6 bypass after reset
        bypass_chk("R6 bypass", 12'hABC, 12'h123, 12'hFFF);
        bypass_chk("R6 bypass", 0, 12'h800, 12'h7FF);

        // R3 load bank A per channel with each single mask
        for (int c = 0; c < 3; c++) begin
            wctrl(0, 0, 0, 4 >> c);
            wptr(0);
            for (int i = 0; i < DEPTH; i++) wdata((c * 1111 + i * 37 + 5) & 12'hFFF);
        end
        rreg(2'd1, d); check("R3 pointer advanced", longint'(d[5:0]), DEPTH);
        // R4 write past the end is ignored
        wdata(12'h5A5);
        rreg(2'd1, d); check("R4 pointer held at 34", longint'(d[5:0]), DEPTH);
        wptr(50);
        rreg(2'd1, d); check("R4 pointer clamp", longint'(d[5:0]), DEPTH);

        // R2 pending mode not applied before frame start
        wctrl(2, 0, 1, 7);
        rreg(2'd0, d);
        check("R2 pending mode", longint'(d[1:0]), 2);
        check("R2 active mode held", longint'(d[17:16]), 0);
        bypass_chk("R2 still bypass", 12'h040, 12'h080, 12'h0C0);
        fstart();
        rreg(2'd0, d); check("R2 active mode applied", longint'(d[17:16]), 2);
        sweep("R5 lookup bank A", 0);

        // R8 load bank B while A active
        wptr(0);
        for (int i = 0; i < DEPTH; i++) wdata((3000 + i * 29) & 12'hFFF);
        wctrl(2, 0, 1, 2);
        wptr(3);
        for (int i = 0; i < 10; i++) wdata(12'h100 + i);
        sweep("R8 active bank A unaffected", 0);

        // R2 pending bank switch waits for frame start
        wctrl(2, 1, 1, 7);
        sweep("R2 bank switch pending", 0);
        fstart();
        rreg(2'd0, d); check("R2 active bank applied", longint'(d[20]), 1);
        sweep("R5 lookup bank B", 1);

        // R7 power off forces bypass
        wreg(2'd3, 32'd3);
        @(negedge clk);
        rreg(2'd3, d); check("R7 status off", longint'(d[8]), 1);
        bypass_chk("R7 gated bypass", 12'h3C0, 12'h000, 12'h840);
        // R9 neutral values hold
        wreg(2'd3, 32'd1);
        repeat (6) @(negedge clk);
        rreg(2'd3, d); check("R9 force 1 holds off", longint'(d[8]), 1);
        wreg(2'd3, 32'd2);
        repeat (6) @(negedge clk);
        rreg(2'd3, d); check("R9 force 2 holds off", longint'(d[8]), 1);
        // R7 wake timing: write edge, then 4 cycles
        wreg(2'd3, 32'd0);
        repeat (3) @(negedge clk);
        rreg(2'd3, d); check("R7 still waking", longint'(d[8]), 1);
        @(negedge clk);
        rreg(2'd3, d); check("R7 powered after 4", longint'(d[8]), 0);
        pix(12'h000, 12'hFC0, 12'h440, o);
        check("R5 lookup after wake", longint'(o),
              (longint'(model[1][0][0]) << 24) | (longint'(model[1][1][33]) << 12) |
               longint'(model[1][2][17]));
        // R9 neutral force while awake keeps it awake
        wreg(2'd3, 32'd2);
        repeat (4) @(negedge clk);
        rreg(2'd3, d); check("R9 force 2 holds on", longint'(d[8]), 0);

        // R3 mask 7 writes all channels at once into bank A (inactive)
        wctrl(2, 1, 0, 7);
        wptr(20);
        wdata(12'h777);
        wctrl(2, 0, 0, 7);
        fstart();
        pix(20 << 6, 20 << 6, 20 << 6, o);
        check("R3 mask 7 all channels", longint'(o), longint'({12'h777, 12'h777, 12'h777}));

        // R6 mode 1 acts as bypass
        wctrl(1, 0, 0, 7);
        fstart();
        bypass_chk("R6 mode 1 bypass", 12'h555, 12'hAAA, 12'h0F0);
        wctrl(0, 0, 0, 7);
        fstart();
        bypass_chk("R6 mode 0 bypass", 12'h001, 12'hFFE, 12'h3C3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule